// File: doc/BRIEF.md
# Descriptor Chain Fetcher

This block lets a DMA channel run a chain of transfers without processor involvement. When the channel finishes its current transfer it pulses a terminal-count input and presents its current next-descriptor pointer. If that pointer is nonzero and aligned to 8 bytes, the block reads an eight-word descriptor from memory over a simple one-outstanding word-read port. It then presents the new control word, transfer count, source, destination and next pointer together, with a single load strobe that also restarts the channel.

A zero pointer ends the chain, and only then is completion reported, through a one-cycle done pulse. A misaligned pointer or a bus error on any descriptor read stops the chain with a one-cycle error pulse. A mode input selects 64-bit addressing. With it low, the upper pointer half is ignored, and the upper-half descriptor words are still read but discarded.

Top module: `desc_chain_fetcher`

## Requirements
- R1: After reset, rdReq, ldStrobe, chainDone and chainErr are low and all load outputs are zero.
- R2: A tcPulse while idle, with a nonzero 8-byte-aligned pointer, starts fetching in the next cycle. Word i (i = 0..7) is read at pointer + 4·i, strictly in order, one read at a time. rdReq and rdAddr hold steady until the cycle in which rdAck is high.
- R3: Descriptor words map to the outputs in this order: word 0 to ldCtrl, word 1 to ldCount (in source-width units), word 2 to the low half of ldSrc, word 3 to the high half of ldSrc, word 4 to the low half of ldDst, word 5 to the high half of ldDst, word 6 to the low half of ldNext, word 7 to the high half of ldNext.
- R4: ldStrobe is high for exactly one cycle, the cycle after the eighth read is acknowledged. All load outputs change together at that point and hold until the next ldStrobe.
- R5: With wideAddr low, the upper 32 bits of curPtr take no part in the zero test, the alignment test or rdAddr (the upper half of rdAddr is 0). Words 3, 5 and 7 are still read, but the upper halves of ldSrc, ldDst and ldNext load as zero.
- R6: With wideAddr high, all 64 pointer bits are used for the zero test, the alignment test and rdAddr, and the upper output halves come from words 3, 5 and 7.
- R7: A tcPulse while idle with a zero effective pointer gives a one-cycle chainDone in the next cycle and issues no read.
- R8: chainDone is never high while a chain continues, so it never coincides with ldStrobe or chainErr.
- R9: A read acknowledged with rdErr high ends the fetch. chainErr pulses for one cycle in the next cycle, no further read is issued, no ldStrobe follows, and the load outputs keep their previous values.
- R10: A tcPulse while idle with a nonzero effective pointer whose low three bits are not all zero gives a one-cycle chainErr in the next cycle and issues no read.
- R11: A tcPulse that arrives while a fetch or load is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tcPulse | input | 1 | Channel reached terminal count |
| curPtr | input | 64 | Channel's current next-descriptor pointer |
| wideAddr | input | 1 | 1 = 64-bit addressing |
| rdReq | output | 1 | Word read request |
| rdAddr | output | 64 | Byte address of requested word |
| rdAck | input | 1 | Read response valid |
| rdData | input | 32 | Read response data |
| rdErr | input | 1 | Read response is a bus error |
| ldStrobe | output | 1 | Reload channel registers and restart |
| ldCtrl | output | 32 | New control word |
| ldCount | output | 32 | New transfer count |
| ldSrc | output | 64 | New source address |
| ldDst | output | 64 | New destination address |
| ldNext | output | 64 | New next-descriptor pointer |
| chainDone | output | 1 | Final completion of the chain |
| chainErr | output | 1 | Chain stopped by error |

## Verification
The bench aims at the pointer edge cases. It uses a pointer with a nonzero upper half and a zero lower half in both addressing modes, where a design that tests the wrong bits would either end the chain early or fetch from address zero. It uses misaligned pointers, where a design that skips the check would start reading. It injects a bus error at the first, a middle and the last word, where a faulty design would still strobe a load or corrupt the outputs. It also pulses tcPulse again during a fetch, which a careless design would take as a restart at a different base. Variable read latency finds address changes made before the acknowledge arrives.

// File: rtl/desc_chain_pkg.sv
package desc_chain_pkg;
  // Descriptor layout: order is defined behaviour, consumers decode by index
  localparam int DESC_WORDS = 8;
  localparam int W_CTRL   = 0;
  localparam int W_COUNT  = 1;
  localparam int W_SRC_LO = 2;
  localparam int W_SRC_HI = 3;
  localparam int W_DST_LO = 4;
  localparam int W_DST_HI = 5;
  localparam int W_NXT_LO = 6;
  localparam int W_NXT_HI = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOAD  = 2'd2
  } fetchState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;    // latch pointer and mode, clear word index
    logic capture;  // store read word, advance index
    logic load;     // copy staged descriptor to output registers
  } dpCmd_t;
endpackage

// File: rtl/desc_chain_dp.sv
module desc_chain_dp
  import desc_chain_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int ALIGN_BITS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic [2*WORD_W-1:0] curPtr,
  input  logic                wideAddr,
  input  logic [WORD_W-1:0]   rdData,
  output logic [2*WORD_W-1:0] rdAddr,
  output logic                lastWord,
  output logic                ptrZero,
  output logic                ptrMisaligned,
  output logic [WORD_W-1:0]   ldCtrl,
  output logic [WORD_W-1:0]   ldCount,
  output logic [2*WORD_W-1:0] ldSrc,
  output logic [2*WORD_W-1:0] ldDst,
  output logic [2*WORD_W-1:0] ldNext
);
  localparam int PTR_W      = 2 * WORD_W;
  localparam int BYTES      = WORD_W / 8;
  localparam int ADDR_SHIFT = $clog2(BYTES);
  localparam int IDX_W      = $clog2(DESC_WORDS);

  logic [PTR_W-1:0]  effPtr;
  logic [PTR_W-1:0]  basePtr;
  logic              wideLatch;
  logic [IDX_W-1:0]  wordIdx;
  logic [WORD_W-1:0] stage [DESC_WORDS];

  // Narrow mode discards the upper pointer half entirely
  assign effPtr        = wideAddr ? curPtr : {{WORD_W{1'b0}}, curPtr[WORD_W-1:0]};
  assign ptrZero       = (effPtr == '0);
  assign ptrMisaligned = |effPtr[ALIGN_BITS-1:0];
  assign lastWord      = (wordIdx == IDX_W'(DESC_WORDS - 1));
  assign rdAddr        = basePtr + (PTR_W'(wordIdx) << ADDR_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      basePtr   <= '0;
      wideLatch <= 1'b0;
      wordIdx   <= '0;
    end else if (cmd.start) begin
      basePtr   <= effPtr;
      wideLatch <= wideAddr;
      wordIdx   <= '0;
    end else if (cmd.capture) begin
      wordIdx   <= wordIdx + 1'b1;
    end
  end

  generate
    for (genvar w = 0; w < DESC_WORDS; w++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                       stage[w] <= '0;
        else if (cmd.capture && wordIdx == IDX_W'(w))    stage[w] <= rdData;
      end
    end
  endgenerate

  // Output registers: all change on the same edge. The final word is
  // taken straight from rdData since it is captured on the same edge.
  logic [WORD_W-1:0] lastHi;
  logic [WORD_W-1:0] hiMask;
  assign lastHi = rdData;
  assign hiMask = wideLatch ? {WORD_W{1'b1}} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldCtrl  <= '0;
      ldCount <= '0;
      ldSrc   <= '0;
      ldDst   <= '0;
      ldNext  <= '0;
    end else if (cmd.load) begin
      ldCtrl  <= stage[W_CTRL];
      ldCount <= stage[W_COUNT];
      ldSrc   <= {stage[W_SRC_HI] & hiMask, stage[W_SRC_LO]};
      ldDst   <= {stage[W_DST_HI] & hiMask, stage[W_DST_LO]};
      ldNext  <= {lastHi & hiMask, stage[W_NXT_LO]};
    end
  end

  // R5: narrow mode never produces a nonzero upper half
  p_narrow_hi_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && !wideLatch) |=> (ldSrc[PTR_W-1:WORD_W] == '0 &&
                                  ldDst[PTR_W-1:WORD_W] == '0 &&
                                  ldNext[PTR_W-1:WORD_W] == '0));

  // R4: outputs only move on a load
  p_hold_outputs_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> ($stable(ldCtrl) && $stable(ldSrc) && $stable(ldNext)));
endmodule

// File: rtl/desc_chain_ctrl.sv
module desc_chain_ctrl
  import desc_chain_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   tcPulse,
  input  logic   rdAck,
  input  logic   rdErr,
  input  logic   lastWord,
  input  logic   ptrZero,
  input  logic   ptrMisaligned,
  output dpCmd_t cmd,
  output logic   rdReq,
  output logic   ldStrobe,
  output logic   chainDone,
  output logic   chainErr
);
  fetchState_t state, stateNext;
  logic        acceptTc;
  logic        goodWord;
  logic        badWord;

  assign acceptTc = (state == ST_IDLE) && tcPulse;
  assign goodWord = (state == ST_FETCH) && rdAck && !rdErr;
  assign badWord  = (state == ST_FETCH) && rdAck && rdErr;

  always_comb begin
    stateNext   = state;
    cmd         = '0;
    unique case (state)
      ST_IDLE: begin
        if (acceptTc && !ptrZero && !ptrMisaligned) begin
          cmd.start = 1'b1;
          stateNext = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (badWord) begin
          stateNext = ST_IDLE;
        end else if (goodWord) begin
          cmd.capture = 1'b1;
          if (lastWord) begin
            cmd.load  = 1'b1;
            stateNext = ST_LOAD;
          end
        end
      end
      ST_LOAD:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      chainDone <= 1'b0;
      chainErr  <= 1'b0;
    end else begin
      state     <= stateNext;
      chainDone <= acceptTc && ptrZero;
      chainErr  <= (acceptTc && !ptrZero && ptrMisaligned) || badWord;
    end
  end

  assign rdReq    = (state == ST_FETCH);
  assign ldStrobe = (state == ST_LOAD);

  // R9: an errored read ends the fetch with an error pulse
  p_err_stops_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAck && rdErr) |=> (!rdReq && chainErr && !ldStrobe));

  // R8: completion never overlaps a load or an error
  p_done_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ldStrobe, chainDone, chainErr}));

  // R4: single-cycle strobe
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    ldStrobe |=> !ldStrobe);

  // R11: a pulse during fetch does not restart or end it
  p_tc_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && tcPulse && !rdAck) |=> (rdReq && !chainDone && !chainErr));
endmodule

// File: rtl/desc_chain_fetcher.sv
module desc_chain_fetcher
  import desc_chain_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int ALIGN_BITS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tcPulse,
  input  logic [2*WORD_W-1:0] curPtr,
  input  logic                wideAddr,
  output logic                rdReq,
  output logic [2*WORD_W-1:0] rdAddr,
  input  logic                rdAck,
  input  logic [WORD_W-1:0]   rdData,
  input  logic                rdErr,
  output logic                ldStrobe,
  output logic [WORD_W-1:0]   ldCtrl,
  output logic [WORD_W-1:0]   ldCount,
  output logic [2*WORD_W-1:0] ldSrc,
  output logic [2*WORD_W-1:0] ldDst,
  output logic [2*WORD_W-1:0] ldNext,
  output logic                chainDone,
  output logic                chainErr
);
  localparam int PTR_W = 2 * WORD_W;
  localparam int BYTES = WORD_W / 8;

  dpCmd_t cmd;
  logic   lastWord;
  logic   ptrZero;
  logic   ptrMisaligned;

  desc_chain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tcPulse(tcPulse), .rdAck(rdAck), .rdErr(rdErr),
    .lastWord(lastWord), .ptrZero(ptrZero), .ptrMisaligned(ptrMisaligned),
    .cmd(cmd), .rdReq(rdReq), .ldStrobe(ldStrobe),
    .chainDone(chainDone), .chainErr(chainErr)
  );

  desc_chain_dp #(.WORD_W(WORD_W), .ALIGN_BITS(ALIGN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .curPtr(curPtr), .wideAddr(wideAddr),
    .rdData(rdData), .rdAddr(rdAddr), .lastWord(lastWord),
    .ptrZero(ptrZero), .ptrMisaligned(ptrMisaligned),
    .ldCtrl(ldCtrl), .ldCount(ldCount), .ldSrc(ldSrc), .ldDst(ldDst), .ldNext(ldNext)
  );

  // R2: request and address held until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr)));

  // R2: consecutive reads step by one word
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAck && !rdErr) |=> (ldStrobe || rdAddr == $past(rdAddr) + PTR_W'(BYTES)));

  // R4: a load follows a good acknowledge
  p_load_after_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    ldStrobe |-> $past(rdAck && !rdErr && rdReq));

  // R2: word reads are word-aligned
  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdAddr[$clog2(BYTES)-1:0] == '0));
endmodule

// File: tb/tb_desc_chain_fetcher.sv
module tb_desc_chain_fetcher;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tcPulse = 1'b0;
  logic [63:0] curPtr = '0;
  logic        wideAddr = 1'b0;
  logic        rdReq;
  logic [63:0] rdAddr;
  logic        rdAck = 1'b0;
  logic [31:0] rdData = '0;
  logic        rdErr = 1'b0;
  logic        ldStrobe;
  logic [31:0] ldCtrl, ldCount;
  logic [63:0] ldSrc, ldDst, ldNext;
  logic        chainDone, chainErr;

  always #4 clk = ~clk;

  desc_chain_fetcher dut (
    .clk(clk), .rstN(rstN), .tcPulse(tcPulse), .curPtr(curPtr), .wideAddr(wideAddr),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData), .rdErr(rdErr),
    .ldStrobe(ldStrobe), .ldCtrl(ldCtrl), .ldCount(ldCount), .ldSrc(ldSrc),
    .ldDst(ldDst), .ldNext(ldNext), .chainDone(chainDone), .chainErr(chainErr)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int cyc = 0;

  logic [63:0] expBase = '0;
  int readCnt = 0;
  int errAt = 99;
  int waitCnt = 0;

  function automatic logic [31:0] memWord(logic [63:0] a);
    return (a[31:0] * 32'h9E3779B1) ^ a[63:32] ^ 32'hC3A5_0F1E;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      finishRun();
    end
  end

  // Memory responder with random latency; checks each read address (R2)
  always @(negedge clk) begin
    if (rdAck) begin
      rdAck = 1'b0;
      rdErr = 1'b0;
    end else if (rdReq) begin
      if (waitCnt > 0) waitCnt--;
      else begin
        chk(rdAddr == expBase + 64'(4 * readCnt), "R2 address", rdAddr,
            expBase + 64'(4 * readCnt));
        rdData = memWord(rdAddr);
        rdErr  = (readCnt == errAt);
        rdAck  = 1'b1;
        readCnt++;
        waitCnt = int'($urandom % 4);
      end
    end
  end

  logic sReq, sDone, sErr;

  task automatic pulseTc(logic [63:0] p, logic w);
    @(negedge clk);
    curPtr = p; wideAddr = w; tcPulse = 1'b1;
    @(posedge clk); #1;
    sReq = rdReq; sDone = chainDone; sErr = chainErr;
    @(negedge clk);
    tcPulse = 1'b0;
  endtask

  // Runs a pointer expected to start a fetch
  task automatic runChain(logic [63:0] p, logic w, int errIdx, bit extraTc);
    logic [63:0] eff;
    logic [31:0] prevCtrl;
    logic [63:0] prevSrc;
    logic [31:0] wv [8];
    bit seen;
    eff = w ? p : {32'h0, p[31:0]};
    expBase = eff; readCnt = 0; errAt = errIdx;
    prevCtrl = ldCtrl; prevSrc = ldSrc;
    for (int i = 0; i < 8; i++) wv[i] = memWord(eff + 64'(4 * i));
    pulseTc(p, w);
    chk(sReq && !sDone && !sErr, "R2 start", {61'b0, sReq, sDone, sErr}, 64'h4);
    if (extraTc) begin
      @(negedge clk);
      curPtr = 64'h0000_0000_0000_0040; tcPulse = 1'b1;
      @(negedge clk);
      tcPulse = 1'b0;
    end
    seen = 0;
    for (int k = 0; k < 200 && !seen; k++) begin
      @(posedge clk); #1;
      if (ldStrobe || chainErr) seen = 1;
    end
    chk(seen, "R4 completion", 64'(seen), 64'd1);
    if (errIdx < 8) begin
      chk(chainErr && !ldStrobe, "R9 error pulse", {62'b0, chainErr, ldStrobe}, 64'h2);
      chk(readCnt == errIdx + 1, "R9 reads stop", 64'(readCnt), 64'(errIdx + 1));
      repeat (4) @(posedge clk);
      #1;
      chk(!rdReq && !ldStrobe && !chainErr, "R9 idle after error",
          {61'b0, rdReq, ldStrobe, chainErr}, 64'h0);
      chk(ldCtrl == prevCtrl && ldSrc == prevSrc, "R9 outputs kept",
          {ldCtrl, ldSrc[31:0]}, {prevCtrl, prevSrc[31:0]});
    end else begin
      chk(ldStrobe && rdAck && readCnt == 8, "R4 strobe after eighth ack",
          64'(readCnt), 64'd8);
      chk(!chainDone, "R8 no done mid-chain", 64'(chainDone), 64'd0);
      chk(ldCtrl == wv[0] && ldCount == wv[1], "R3 ctrl/count",
          {ldCtrl, ldCount}, {wv[0], wv[1]});
      chk(ldSrc == {w ? wv[3] : 32'h0, wv[2]}, w ? "R6 src" : "R5 src",
          ldSrc, {w ? wv[3] : 32'h0, wv[2]});
      chk(ldDst == {w ? wv[5] : 32'h0, wv[4]}, w ? "R6 dst" : "R5 dst",
          ldDst, {w ? wv[5] : 32'h0, wv[4]});
      chk(ldNext == {w ? wv[7] : 32'h0, wv[6]}, "R3 next ptr",
          ldNext, {w ? wv[7] : 32'h0, wv[6]});
      if (extraTc) chk(readCnt == 8, "R11 extra pulse ignored", 64'(readCnt), 64'd8);
      @(posedge clk); #1;
      chk(!ldStrobe && !rdReq, "R4 single strobe", {62'b0, ldStrobe, rdReq}, 64'h0);
      chk(ldCtrl == wv[0], "R4 outputs hold", ldCtrl, wv[0]);
    end
  endtask

  task automatic expectDone(logic [63:0] p, logic w, string req);
    pulseTc(p, w);
    chk(sDone && !sReq && !sErr, req, {61'b0, sDone, sReq, sErr}, 64'h4);
    @(posedge clk); #1;
    chk(!chainDone && !rdReq, "R7 done single cycle", {62'b0, chainDone, rdReq}, 64'h0);
  endtask

  task automatic expectMisaligned(logic [63:0] p, logic w);
    pulseTc(p, w);
    chk(sErr && !sReq && !sDone, "R10 misaligned", {61'b0, sErr, sReq, sDone}, 64'h4);
    @(posedge clk); #1;
    chk(!chainErr && !rdReq, "R10 no reads", {62'b0, chainErr, rdReq}, 64'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(!rdReq && !ldStrobe && !chainDone && !chainErr && ldCtrl == 0 && ldNext == 0,
        "R1 reset state", {60'b0, rdReq, ldStrobe, chainDone, chainErr}, 64'h0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(posedge clk);

    // Directed corners
    expectDone(64'h0, 1'b1, "R7 zero pointer");
    expectDone(64'hABCD_0000_0000_0000, 1'b0, "R5 upper half ignored for zero test");
    runChain(64'h0000_0000_0000_1000, 1'b0, 99, 1'b0);
    runChain(64'h0000_0001_0000_0000, 1'b1, 99, 1'b0);
    runChain(64'h1234_5677_8000_0200, 1'b0, 99, 1'b0);
    runChain(64'h0000_0003_0000_0110, 1'b1, 99, 1'b1);
    expectMisaligned(64'h0000_0000_0000_1004, 1'b0);
    expectMisaligned(64'h0000_0000_0000_2002, 1'b1);
    runChain(64'h0000_0000_0000_3008, 1'b0, 0, 1'b0);
    runChain(64'h0000_0000_0000_3108, 1'b1, 4, 1'b0);
    runChain(64'h0000_0000_0000_3208, 1'b0, 7, 1'b0);

    // Random chains
    for (int n = 0; n < 24; n++) begin
      logic [63:0] p;
      logic w;
      p = {$urandom, $urandom & 32'hFFFF_FFF8};
      w = 1'($urandom % 2);
      if ((w ? p : {32'h0, p[31:0]}) == 0) p[3] = 1'b1;
      runChain(p, w, ($urandom % 5 == 0) ? int'($urandom % 8) : 99, 1'($urandom % 3 == 0));
    end
    expectDone(64'h0, 1'b0, "R7 chain end after loads");
    finishRun();
  end
endmodule